// File: doc/BRIEF.md
# Serial Control-Port Host Master

This block is the host end of a four-wire serial control link to a processor. The link has an active-low select, a busy/acknowledge line driven by the device, a serial clock driven by the host, and one shared data line. The data line appears here as a separate output, an output enable and an input, which the pad combines. Each transaction follows the same order. Select goes low. The host waits until the device is not busy. A 24-bit command is shifted out, followed by zero to sixteen 24-bit data words in one direction. Select then goes high again.

The user offers a request with `req_valid`. The request carries a command word, a direction flag, a flag that says whether data words follow, and a 4-bit count field. The block takes write words from `wr_data`, which must always hold the next word to send. It pulses `wr_take` in the cycle after it has copied that word. Read words come back on `rd_data` with a one-cycle `rd_valid`. `done` pulses at the end of each transaction. On a read, the device may raise busy again after the command, and the block waits for it to drop before it clocks in any data.

Top module: `sctl_host_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, and `spi_sck`, `spi_sdo_en`, `busy`, `done` and `rd_valid` are all 0.
- R2: After select falls, no rising serial clock edge occurs while `spi_ack` is high. Shifting starts only once the device reports not busy.
- R3: The command is sent as 24 bits, MSB first. `spi_sdo` changes only while the serial clock is low, so it is stable at every rising edge.
- R4: The count field holds the number of data words minus one (0 means 1 word, 15 means 16 words). A transaction with data gives exactly 24 × (1 + count + 1) rising clock edges.
- R5: On a write, each data word is sent MSB first, in the order it is presented on `wr_data`. `wr_take` pulses once for each word, one cycle after that word has been loaded.
- R6: On a read, the block drives the data line only during the command (`spi_sdo_en` is 0 during the data phase). It waits for `spi_ack` to be low before the first data clock. It returns each word, assembled MSB first from bits sampled on rising edges, with one `rd_valid` pulse.
- R7: When `req_has_data` is 0, exactly 24 clock edges follow, and then select rises.
- R8: Within a word, consecutive rising serial clock edges are 2 × DIV_HALF system clocks apart.
- R9: `busy` is high from the cycle after a request is accepted until the transaction ends. A request offered while busy is ignored and does not alter the running transaction.
- R10: `done` is a single-cycle pulse that appears together with select high. The serial clock is low whenever select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Offer a transaction; taken only when idle |
| req_cmd | input | WORD_W | Command word |
| req_count | input | CNT_W | Number of data words minus one |
| req_read | input | 1 | 1 = read data words, 0 = write them |
| req_has_data | input | 1 | 0 = command-only transaction |
| wr_data | input | WORD_W | Next write word to send |
| wr_take | output | 1 | Pulse: the presented write word was consumed |
| rd_data | output | WORD_W | Received read word |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new word |
| done | output | 1 | Pulse: transaction finished |
| busy | output | 1 | Transaction in progress |
| spi_cs_n | output | 1 | Active-low device select |
| spi_ack | input | 1 | Device busy/acknowledge, high = hold off |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_en | output | 1 | Output enable for the shared data line |
| spi_sdi | input | 1 | Serial data in |

## Verification
The bench models the device busy line. It holds busy high for a random time after select falls and again after a read command, and it counts any rising clock edge seen while busy is high. A design that samples busy through a stale synchronizer would clock into a busy device. Bursts of 1 and 16 words and command-only transactions expose count decoding that is off by one: the number of rising edges would differ by 24. A second request injected mid-transaction catches a design that restarts or reloads its command, which shows up as a corrupted received command or a second select fall. Read bursts check that the data line is released and that words are assembled MSB first, so a design that drives during reads or reverses the bit order is reported.

// File: rtl/sctl_pkg.sv
// Package: shared state encoding for the serial control-port host master.
// Assumes nothing beyond being compiled before the modules that import it.
package sctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_WAIT,
        ST_CMD,
        ST_DATA_WAIT,
        ST_DATA,
        ST_END
    } sctl_state_t;

endpackage

// File: rtl/sctl_clkgen.sv
// Serial clock generator: while run is high, toggles sck every HALF system
// cycles, starting from low, and flags the cycle of each rising and falling
// edge. When run is low the counter clears and sck rests low.
// Assumes HALF >= 1 and that run is only dropped in the cycle after a fall.
module sctl_clkgen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = run && (cnt == CW'(HALF - 1));
    assign rise = wrap && !sck;
    assign fall = wrap && sck;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/sctl_ack_sync.sv
// Synchronizer for the device busy/acknowledge line. Its reset value is
// "busy", so nothing can be started on a stale idle reading.
// Assumes STAGES >= 1.
module sctl_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_in,
    output logic ack_sync
);
    logic [STAGES-1:0] pipe;

    // Shift the asynchronous level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], ack_in} & {STAGES{1'b1}};
        end
    end

    assign ack_sync = pipe[STAGES-1];
endmodule

// File: rtl/sctl_shifter.sv
// Word shifter shared by transmit and receive. The MSB goes out first. Each
// rising clock edge captures one input bit; each falling edge shifts it in at
// the LSB. A parallel load takes priority over a shift. After W falls the
// register holds the received word.
// Assumes W >= 2.
module sctl_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         capture,
    input  logic         sdi,
    output logic [W-1:0] sr,
    output logic         sout
);
    logic cap_bit;

    // Hold the bit sampled at the last rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_bit <= 1'b0;
        end else if (capture) begin
            cap_bit <= sdi;
        end
    end

    // Parallel load or shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {sr[W-2:0], cap_bit};
        end
    end

    assign sout = sr[W-1];
endmodule

// File: rtl/sctl_host_master.sv
// Host master for a four-wire serial control port. It sequences the select
// line, the busy waits, a command word and a burst of 0..2^CNT_W data words.
// Assumes wr_data always holds the next write word, and that the device
// raises busy within SYNC_STAGES+1 cycles of the event it answers.
module sctl_host_master
    import sctl_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int CNT_W       = 4,
    parameter int DIV_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_cmd,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_read,
    input  logic              req_has_data,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_take,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              busy,
    output logic              spi_cs_n,
    input  logic              spi_ack,
    output logic              spi_sck,
    output logic              spi_sdo,
    output logic              spi_sdo_en,
    input  logic              spi_sdi
);
    localparam int BW     = $clog2(WORD_W);
    localparam int SETTLE = SYNC_STAGES + 1;
    localparam int SW     = $clog2(SETTLE + 1);

    sctl_state_t      state;
    logic [BW-1:0]    bit_cnt;
    logic [CNT_W-1:0] words_left;
    logic [SW-1:0]    settle;
    logic             is_read;
    logic             has_data;
    logic             run;
    logic             ack_s;
    logic             rise_t;
    logic             fall_t;
    logic             word_end;
    logic             accept;
    logic             wr_load;
    logic             sh_load;
    logic [WORD_W-1:0] sh_val;
    logic [WORD_W-1:0] sh_reg;

    sctl_clkgen #(.HALF(DIV_HALF)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sck  (spi_sck),
        .rise (rise_t),
        .fall (fall_t)
    );

    sctl_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_in  (spi_ack),
        .ack_sync(ack_s)
    );

    // Request acceptance, word boundary and write reload decode.
    assign accept   = (state == ST_IDLE) && req_valid;
    assign word_end = fall_t && (bit_cnt == BW'(WORD_W - 1));
    assign wr_load  = word_end && !is_read &&
                      (((state == ST_CMD) && has_data) ||
                       ((state == ST_DATA) && (words_left != '0)));
    assign sh_load  = accept || wr_load;
    assign sh_val   = accept ? req_cmd : wr_data;

    sctl_shifter #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(sh_val),
        .shift   (fall_t),
        .capture (rise_t),
        .sdi     (spi_sdi),
        .sr      (sh_reg),
        .sout    (spi_sdo)
    );

    assign rd_data    = sh_reg;
    assign busy       = (state != ST_IDLE);
    assign spi_sdo_en = (state == ST_CMD_WAIT) || (state == ST_CMD) ||
                        ((state == ST_DATA) && !is_read);

    // Transaction sequencer: select, busy waits, bit and word counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            spi_cs_n   <= 1'b1;
            run        <= 1'b0;
            done       <= 1'b0;
            wr_take    <= 1'b0;
            rd_valid   <= 1'b0;
            bit_cnt    <= '0;
            words_left <= '0;
            settle     <= '0;
            is_read    <= 1'b0;
            has_data   <= 1'b0;
        end else begin
            done     <= 1'b0;
            wr_take  <= 1'b0;
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        spi_cs_n   <= 1'b0;
                        is_read    <= req_read;
                        has_data   <= req_has_data;
                        words_left <= req_count;
                        settle     <= '0;
                        state      <= ST_CMD_WAIT;
                    end
                end
                ST_CMD_WAIT, ST_DATA_WAIT: begin
                    if (settle != SW'(SETTLE)) begin
                        settle <= settle + SW'(1);
                    end else if (!ack_s) begin
                        run     <= 1'b1;
                        bit_cnt <= '0;
                        state   <= (state == ST_CMD_WAIT) ? ST_CMD : ST_DATA;
                    end
                end
                ST_CMD: begin
                    if (word_end) begin
                        bit_cnt <= '0;
                        if (!has_data) begin
                            run   <= 1'b0;
                            state <= ST_END;
                        end else if (is_read) begin
                            run    <= 1'b0;
                            settle <= '0;
                            state  <= ST_DATA_WAIT;
                        end else begin
                            wr_take <= 1'b1;
                            state   <= ST_DATA;
                        end
                    end else if (fall_t) begin
                        bit_cnt <= bit_cnt + BW'(1);
                    end
                end
                ST_DATA: begin
                    if (word_end) begin
                        bit_cnt  <= '0;
                        rd_valid <= is_read;
                        if (words_left == '0) begin
                            run   <= 1'b0;
                            state <= ST_END;
                        end else begin
                            words_left <= words_left - CNT_W'(1);
                            wr_take    <= !is_read;
                        end
                    end else if (fall_t) begin
                        bit_cnt <= bit_cnt + BW'(1);
                    end
                end
                ST_END: begin
                    spi_cs_n <= 1'b1;
                    done     <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sctl_host_master_chk.sv
// Checker for sctl_host_master, attached by bind. It watches only the ports.
module sctl_host_master_chk #(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              done,
    input logic              busy,
    input logic              spi_cs_n,
    input logic              spi_sck,
    input logic              spi_sdo,
    input logic              spi_sdo_en
);
    // R10
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R3
    sdo_hold_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_sdo));

    // R6
    drive_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdo_en |-> !spi_cs_n);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_with_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && !spi_sck));

    // R9
    busy_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R9
    select_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);
endmodule

bind sctl_host_master sctl_host_master_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .done      (done),
    .busy      (busy),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_sdo   (spi_sdo),
    .spi_sdo_en(spi_sdo_en)
);

// File: tb/sctl_host_master_tb.sv
// Bench for sctl_host_master: a device model plus directed and seeded random
// transactions.
module sctl_host_master_tb;
    localparam int W    = 24;
    localparam int HALF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [W-1:0]  req_cmd = '0;
    logic [3:0]    req_count = '0;
    logic          req_read = 1'b0;
    logic          req_has_data = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          wr_take;
    logic [W-1:0]  rd_data;
    logic          rd_valid;
    logic          done;
    logic          busy;
    logic          spi_cs_n;
    logic          spi_ack = 1'b0;
    logic          spi_sck;
    logic          spi_sdo;
    logic          spi_sdo_en;
    logic          spi_sdi = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0] wdata [16];
    logic [W-1:0] rdata [16];
    logic [W-1:0] wr_rx [16];
    logic [W-1:0] cmd_rx;
    logic [W-1:0] cur;
    int  rises, ack_timer, pre_hold, post_hold, last_rise, cycle;
    int  bad_period, ack_viol, oe_viol, widx, ridx, done_cnt, done_bad, csfall;
    logic prev_sck, prev_cs, prev_done, txn_read, txn_has;

    always #5 clk = ~clk;

    sctl_host_master #(.WORD_W(W), .CNT_W(4), .DIV_HALF(HALF), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_count(req_count), .req_read(req_read), .req_has_data(req_has_data),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .busy(busy), .spi_cs_n(spi_cs_n), .spi_ack(spi_ack),
        .spi_sck(spi_sck), .spi_sdo(spi_sdo), .spi_sdo_en(spi_sdo_en), .spi_sdi(spi_sdi)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_rises(input logic has, input logic [3:0] cnt);
        return has ? W * (2 + int'(cnt)) : W;
    endfunction

    // Device model, sampled away from the active edge.
    always @(negedge clk) begin
        cycle++;
        if (ack_timer > 0) ack_timer--;
        if (req_valid && !busy) ack_timer = pre_hold;
        if (prev_cs && !spi_cs_n) begin
            csfall++;
            rises = 0;
        end
        if (spi_sck && !prev_sck && !spi_cs_n) begin
            if (spi_ack) ack_viol++;
            if (rises >= W && txn_read && spi_sdo_en) oe_viol++;
            if (rises > 0 && (rises % W) != 0 && (cycle - last_rise) != 2 * HALF) bad_period++;
            cur = {cur[W-2:0], spi_sdo};
            rises++;
            last_rise = cycle;
            if (rises % W == 0) begin
                if (rises == W) cmd_rx = cur;
                else if (rises / W - 2 < 16) wr_rx[rises / W - 2] = cur;
                if (rises == W && txn_read && txn_has) ack_timer = post_hold;
            end
            if (rises >= W && (rises - W) / W < 16)
                spi_sdi = rdata[(rises - W) / W][W - 1 - (rises - W) % W];
        end
        if (wr_take) begin
            widx++;
            if (widx < 16) wr_data = wdata[widx];
        end
        if (rd_valid) begin
            if (ridx < 16) check("R6 read word", 32'(rd_data), 32'(rdata[ridx]));
            ridx++;
        end
        if (done) begin
            done_cnt++;
            if (!spi_cs_n || spi_sck || prev_done) done_bad++;
        end
        spi_ack   = (ack_timer > 0);
        prev_sck  = spi_sck;
        prev_cs   = spi_cs_n;
        prev_done = done;
    end

    task automatic run_txn(input logic [W-1:0] cmd, input logic [3:0] cnt,
                           input logic rd, input logic has, input int pre, input int post,
                           input logic inject);
        int n;
        int guard;
        n = has ? int'(cnt) + 1 : 0;
        for (int i = 0; i < 16; i++) begin
            wdata[i] = W'($urandom);
            rdata[i] = W'($urandom);
        end
        @(negedge clk);
        pre_hold = pre; post_hold = post; txn_read = rd; txn_has = has;
        bad_period = 0; ack_viol = 0; oe_viol = 0; widx = 0; ridx = 0;
        done_cnt = 0; done_bad = 0; csfall = 0; cmd_rx = '0;
        wr_data = wdata[0];
        req_cmd = cmd; req_count = cnt; req_read = rd; req_has_data = has;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 busy after accept", 32'(busy), 32'd1);
        if (inject) begin
            repeat (30) @(negedge clk);
            check("R9 busy mid transaction", 32'(busy), 32'd1);
            req_cmd = ~cmd; req_count = ~cnt; req_read = ~rd;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        check("R3 command received", 32'(cmd_rx), 32'(cmd));
        if (has) check("R4 edge count", 32'(rises), 32'(exp_rises(has, cnt)));
        else     check("R7 edge count", 32'(rises), 32'(exp_rises(has, cnt)));
        check("R2 clock while device busy", 32'(ack_viol), 32'd0);
        check("R8 clock period", 32'(bad_period), 32'd0);
        check("R10 done pulses", 32'(done_cnt), 32'd1);
        check("R10 done shape", 32'(done_bad), 32'd0);
        check("R9 one select per transaction", 32'(csfall), 32'd1);
        check("R9 idle after done", 32'(busy), 32'd0);
        if (has && !rd) begin
            check("R5 write takes", 32'(widx), 32'(n));
            for (int i = 0; i < n; i++) check("R5 write word", 32'(wr_rx[i]), 32'(wdata[i]));
        end
        if (has && rd) begin
            check("R6 read words", 32'(ridx), 32'(n));
            check("R6 line released", 32'(oe_viol), 32'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        cycle = 0; rises = 0; ack_timer = 0; pre_hold = 0; post_hold = 0; last_rise = 0;
        prev_sck = 0; prev_cs = 1; prev_done = 0; txn_read = 0; txn_has = 0; cur = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 select", 32'(spi_cs_n), 32'd1);
        check("R1 clock", 32'(spi_sck), 32'd0);
        check("R1 enable", 32'(spi_sdo_en), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        // Directed corners
        run_txn(24'h000060, 4'd0, 1'b0, 1'b0, 0, 0, 1'b0);
        run_txn(24'hA5C3F0, 4'd0, 1'b0, 1'b1, 5, 0, 1'b0);
        run_txn(24'h123456, 4'd15, 1'b1, 1'b1, 0, 12, 1'b0);
        run_txn(24'hFEDCBA, 4'd15, 1'b0, 1'b1, 9, 0, 1'b0);
        run_txn(24'h800001, 4'd0, 1'b1, 1'b1, 12, 0, 1'b0);
        run_txn(24'h0F0F0F, 4'd3, 1'b0, 1'b1, 0, 0, 1'b1);
        // Seeded random
        for (int t = 0; t < 30; t++) begin
            run_txn(W'($urandom), 4'($urandom), 1'($urandom), ($urandom % 5) != 0,
                    int'($urandom % 13), int'($urandom % 13), ($urandom % 4) == 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule